// File: doc/BRIEF.md
# Event-to-Task Routing Matrix

This block links peripherals to one another without processor help. Peripherals raise single-cycle event pulses on a wide input vector. Other peripherals accept single-cycle trigger pulses on a wide output vector. In between sit fifty independent routing channels. Each channel stores one event selector and one task selector. When a channel is switched on and the event it selects pulses, the task it selects pulses on the next clock.

Software sets the block up through a simple word-addressed register bus. The bus has one write strobe and a combinational read port. The map is:

- 0x00: global routing enable in bit 0.
- 0x08 and up: enable-set words.
- 0x10 and up: enable-clear words.
- 0x18 and up: enable-status words.
- 0x40 + channel: one configuration word per channel.

Enables are never written directly. They are only set or cleared one bit at a time, so two agents can change different channels without read-modify-write races. An event or task selector of zero leaves that side of the channel unconnected.

Top module: `evt_route_mx`

## Requirements
- R1: After reset every channel is disabled, the global enable is 0, every selector is 0, all status and configuration reads return 0, and task_o is all zero.
- R2: A write to an enable-set word (0x08 for channels 0-31, 0x09 for channels 32-49) enables each channel whose bit is 1. Channels whose bit is 0 keep their state. The change is visible on the status words (0x18, 0x19) from the cycle after the write. Set and clear words read as 0.
- R3: A write to an enable-clear word (0x10 for channels 0-31, 0x11 for channels 32-49) disables each channel whose bit is 1 and leaves the rest unchanged.
- R4: Channel n maps to bit n of the first set, clear and status word when n < 32, and to bit n-32 of the second word otherwise. Bits 18-31 of the second status word always read 0.
- R5: The configuration word at address 0x40+n holds the event selector of channel n in bits 7:0 and its task selector in bits 15:8. It reads back these 16 bits with bits 31:16 as 0.
- R6: Routing takes one cycle. Take a channel that is enabled, with the global enable at 1, event selector e and task selector k. If event_i[e] is high in cycle t, then task_o[k] is high in cycle t+1, for as many cycles as the event stays high.
- R7: A channel whose event selector is 0 or at least the event count, or whose task selector is 0 or at least the task count, produces no task pulse. This holds even if event_i bit 0 is high.
- R8: While bit 0 of address 0x00 is 0, no event is forwarded. Setting it back to 1 restores routing.
- R9: A disabled channel forwards nothing, even with valid selectors.
- R10: Pulses from several channels that target the same task in the same cycle merge into one high bit. One event may drive several tasks through several channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| event_i | input | NUM_EVT (64) | Event pulses; bit 0 is never selected |
| task_o | output | NUM_TSK (64) | Task trigger pulses; bit 0 stays low |

## Verification
The bench targets the places where this matrix goes wrong. The first is the set and clear words. A design that writes the enables directly would wipe neighbouring channels, so the bench sets and clears bits one at a time and then reads back the whole status word. The second is the split across two words: a wrong offset for channels 32 and up would enable the wrong channel or leave stray status bits. The third is the null and out-of-range selectors, tried with every event line high. A design that treats selector 0 as a real index, or that wraps large selectors, would fire bit 0 or an aliased task. The last is merging: two channels feeding one task in the same cycle must give a single bit, and one event may reach two tasks. The global gate and per-channel disable must each hold the output silent.

// File: rtl/evr_pkg.sv
package evr_pkg;

    // Width of the event and task selectors
    localparam int unsigned ID_W  = 8;
    localparam int unsigned DAT_W = 32;
    localparam int unsigned ADR_W = 8;

    // Word address map
    localparam int unsigned ADR_CLKCFG   = 'h00;
    localparam int unsigned ADR_SET_BASE = 'h08;
    localparam int unsigned ADR_CLR_BASE = 'h10;
    localparam int unsigned ADR_STA_BASE = 'h18;
    localparam int unsigned ADR_CFG_BASE = 'h40;
    localparam int unsigned MAX_WORDS    = 8;

    // Per-channel routing configuration; event selector in the low byte
    typedef struct packed {
        logic [ID_W-1:0] tsk;
        logic [ID_W-1:0] evt;
    } route_cfg_t;

    localparam int unsigned CFG_W = $bits(route_cfg_t);

    // A selector is live when it is non-zero and names an implemented line
    function automatic logic id_live(input logic [ID_W-1:0] id, input int unsigned limit);
        return (id != '0) && (32'(id) < limit);
    endfunction

    // Address compare helper
    function automatic logic adr_hit(input logic [ADR_W-1:0] a, input int unsigned target);
        return a == ADR_W'(target);
    endfunction

endpackage

// File: rtl/evr_regs.sv
module evr_regs
    import evr_pkg::*;
#(
    parameter int unsigned NUM_CH = 50
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADR_W-1:0]         bus_addr,
    input  logic [DAT_W-1:0]         bus_wdata,
    output logic [DAT_W-1:0]         bus_rdata,
    output logic                     clk_en_o,
    output logic [NUM_CH-1:0]        chan_en_o,
    output route_cfg_t [NUM_CH-1:0]  cfg_o
);

    localparam int unsigned NWORDS = (NUM_CH + DAT_W - 1) / DAT_W;
    localparam int unsigned PADW   = NWORDS * DAT_W;

    logic              clk_en_q;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] en_next;
    logic [PADW-1:0]   set_mask;
    logic [PADW-1:0]   clr_mask;
    logic [PADW-1:0]   en_pad;
    route_cfg_t [NUM_CH-1:0] cfg_q;

    // Write decode for the set and clear words
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_wr && adr_hit(bus_addr, ADR_SET_BASE + w))
                set_mask[w*DAT_W +: DAT_W] = bus_wdata;
            if (bus_wr && adr_hit(bus_addr, ADR_CLR_BASE + w))
                clr_mask[w*DAT_W +: DAT_W] = bus_wdata;
        end
    end

    // Clear has priority over set for the same channel
    always_comb begin
        en_next = (en_q | set_mask[NUM_CH-1:0]) & ~clr_mask[NUM_CH-1:0];
    end

    always_comb begin
        en_pad = '0;
        en_pad[NUM_CH-1:0] = en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            clk_en_q <= 1'b0;
        end else begin
            en_q <= en_next;
            if (bus_wr && adr_hit(bus_addr, ADR_CLKCFG))
                clk_en_q <= bus_wdata[0];
        end
    end

    // One configuration word per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[c] <= '0;
            else if (bus_wr && adr_hit(bus_addr, ADR_CFG_BASE + c))
                cfg_q[c] <= route_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    // Combinational read port; write-only and unmapped words read 0
    always_comb begin
        bus_rdata = '0;
        if (adr_hit(bus_addr, ADR_CLKCFG))
            bus_rdata[0] = clk_en_q;
        for (int w = 0; w < NWORDS; w++) begin
            if (adr_hit(bus_addr, ADR_STA_BASE + w))
                bus_rdata = en_pad[w*DAT_W +: DAT_W];
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (adr_hit(bus_addr, ADR_CFG_BASE + c))
                bus_rdata = DAT_W'(cfg_q[c]);
        end
    end

    assign clk_en_o  = clk_en_q;
    assign chan_en_o = en_q;
    assign cfg_o     = cfg_q;

    // Checks on the first enable word
    p_set_enables_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && adr_hit(bus_addr, ADR_SET_BASE))
        |=> ((en_pad[DAT_W-1:0] & $past(bus_wdata)) == ($past(bus_wdata) & $past(en_next_lo_mask()))));

    p_set_keeps_others_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && adr_hit(bus_addr, ADR_SET_BASE))
        |=> ((en_pad[DAT_W-1:0] & ~$past(bus_wdata)) == ($past(en_pad[DAT_W-1:0]) & ~$past(bus_wdata))));

    p_clr_disables_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && adr_hit(bus_addr, ADR_CLR_BASE))
        |=> ((en_pad[DAT_W-1:0] & $past(bus_wdata)) == '0));

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(en_q));

    // Implemented channels within the first word
    function automatic logic [DAT_W-1:0] en_next_lo_mask();
        logic [PADW-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CH; i++) m[i] = 1'b1;
        return m[DAT_W-1:0];
    endfunction

endmodule

// File: rtl/evr_chan.sv
module evr_chan
    import evr_pkg::*;
#(
    parameter int unsigned NUM_EVT = 64,
    parameter int unsigned NUM_TSK = 64
) (
    input  logic               clk_en,
    input  logic               en,
    input  route_cfg_t         cfg,
    input  logic [NUM_EVT-1:0] event_i,
    output logic [NUM_TSK-1:0] req_o
);

    localparam int unsigned EW = $clog2(NUM_EVT);
    localparam int unsigned TW = $clog2(NUM_TSK);

    logic evt_ok;
    logic tsk_ok;
    logic ev_sel;
    logic hit;

    always_comb begin
        evt_ok = id_live(cfg.evt, NUM_EVT);
        tsk_ok = id_live(cfg.tsk, NUM_TSK);
        ev_sel = 1'b0;
        if (evt_ok)
            ev_sel = event_i[cfg.evt[EW-1:0]];
        hit = clk_en && en && tsk_ok && ev_sel;
    end

    // One-hot request toward the selected task line
    always_comb begin
        req_o = '0;
        if (hit)
            req_o[cfg.tsk[TW-1:0]] = 1'b1;
    end

endmodule

// File: rtl/evr_fanout.sv
module evr_fanout #(
    parameter int unsigned NUM_CH  = 50,
    parameter int unsigned NUM_TSK = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CH-1:0][NUM_TSK-1:0]  req_i,
    output logic [NUM_TSK-1:0]              task_q
);

    logic [NUM_TSK-1:0] merged;

    // Requests to the same task OR together into one bit
    always_comb begin
        merged = '0;
        for (int c = 0; c < NUM_CH; c++)
            merged = merged | req_i[c];
    end

    always_ff @(posedge clk) begin
        if (rst)
            task_q <= '0;
        else
            task_q <= merged;
    end

endmodule

// File: rtl/evt_route_mx.sv
module evt_route_mx
    import evr_pkg::*;
#(
    parameter int unsigned NUM_CH  = 50,
    parameter int unsigned NUM_EVT = 64,
    parameter int unsigned NUM_TSK = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] event_i,
    output logic [NUM_TSK-1:0] task_o
);

    logic                            clk_en;
    logic [NUM_CH-1:0]               chan_en;
    route_cfg_t [NUM_CH-1:0]         cfg;
    logic [NUM_CH-1:0][NUM_TSK-1:0]  req;

    evr_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clk_en_o  (clk_en),
        .chan_en_o (chan_en),
        .cfg_o     (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        evr_chan #(.NUM_EVT(NUM_EVT), .NUM_TSK(NUM_TSK)) u_chan (
            .clk_en  (clk_en),
            .en      (chan_en[c]),
            .cfg     (cfg[c]),
            .event_i (event_i),
            .req_o   (req[c])
        );
    end

    evr_fanout #(.NUM_CH(NUM_CH), .NUM_TSK(NUM_TSK)) u_fanout (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .task_q (task_o)
    );

    p_gated_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(clk_en) |-> (task_o == '0));

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(chan_en) == '0) |-> (task_o == '0));

    p_no_event_no_task_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(event_i) == '0) |-> (task_o == '0));

    p_null_task_line_r7: assert property (@(posedge clk) disable iff (rst)
        task_o[0] == 1'b0);

endmodule

// File: tb/evt_route_mx_tb.sv
module evt_route_mx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] event_i = '0;
    logic [63:0] task_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    evt_route_mx u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .event_i   (event_i),
        .task_o    (task_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic set_cfg(input int ch, input logic [7:0] ev, input logic [7:0] tk);
        bus_write(8'(8'h40 + ch), {16'h0, tk, ev});
    endtask

    task automatic quiesce();
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h11, 32'hFFFF_FFFF);
    endtask

    // One-cycle event pulse; task appears one cycle later for one cycle
    task automatic pulse(input string req, input logic [63:0] ev, input logic [63:0] exp);
        @(negedge clk);
        event_i = ev;
        @(negedge clk);
        event_i = '0;
        #1;
        check(req, task_o, exp);
        @(negedge clk);
        #1;
        check(req, task_o, 64'h0);
    endtask

    task automatic t_reset();
        bus_check("R1 clkcfg", 8'h00, 32'h0);
        bus_check("R1 status0", 8'h18, 32'h0);
        bus_check("R1 status1", 8'h19, 32'h0);
        bus_check("R1 cfg0", 8'h40, 32'h0);
        bus_check("R1 cfg49", 8'h71, 32'h0);
        check("R1 task_o", task_o, 64'h0);
    endtask

    task automatic t_enable_words();
        bus_write(8'h08, 32'h0000_00F5);
        bus_check("R2 set lo", 8'h18, 32'h0000_00F5);
        bus_write(8'h08, 32'h0000_0100);
        bus_check("R2 zeros keep", 8'h18, 32'h0000_01F5);
        bus_check("R2 set word reads 0", 8'h08, 32'h0);
        bus_write(8'h10, 32'h0000_0005);
        bus_check("R3 clr lo", 8'h18, 32'h0000_01F0);
        bus_write(8'h09, 32'hFFFF_FFFF);
        bus_check("R4 hi word width", 8'h19, 32'h0003_FFFF);
        bus_check("R4 lo untouched", 8'h18, 32'h0000_01F0);
        bus_write(8'h11, 32'h0000_0001);
        bus_check("R3 clr hi ch32", 8'h19, 32'h0003_FFFE);
        quiesce();
        bus_check("R3 all off lo", 8'h18, 32'h0);
        bus_check("R3 all off hi", 8'h19, 32'h0);
    endtask

    task automatic t_config();
        bus_write(8'h71, 32'hDEAD_2A13);
        bus_check("R5 cfg49", 8'h71, 32'h0000_2A13);
        bus_check("R5 cfg0 untouched", 8'h40, 32'h0);
    endtask

    task automatic t_route();
        quiesce();
        bus_write(8'h00, 32'h1);
        bus_check("R8 clkcfg on", 8'h00, 32'h1);
        set_cfg(3, 8'd5, 8'd9);
        bus_write(8'h08, 32'h1 << 3);
        pulse("R6 ch3 5->9", 64'h1 << 5, 64'h1 << 9);
        set_cfg(40, 8'd7, 8'd63);
        bus_write(8'h09, 32'h1 << 8);
        pulse("R6 R4 ch40 7->63", 64'h1 << 7, 64'h1 << 63);
        pulse("R6 both", (64'h1 << 5) | (64'h1 << 7), (64'h1 << 9) | (64'h1 << 63));
    endtask

    task automatic t_null_ids();
        quiesce();
        set_cfg(4, 8'd6, 8'd0);
        bus_write(8'h08, 32'h1 << 4);
        pulse("R7 task id 0", 64'h1 << 6, 64'h0);
        set_cfg(4, 8'd0, 8'd10);
        pulse("R7 event id 0", '1, 64'h0);
        set_cfg(4, 8'd100, 8'd10);
        pulse("R7 event id range", '1, 64'h0);
        set_cfg(4, 8'd6, 8'd64);
        pulse("R7 task id range", '1, 64'h0);
        set_cfg(4, 8'd6, 8'd10);
        pulse("R7 valid again", 64'h1 << 6, 64'h1 << 10);
    endtask

    task automatic t_gate();
        quiesce();
        set_cfg(3, 8'd5, 8'd9);
        bus_write(8'h08, 32'h1 << 3);
        bus_write(8'h00, 32'h0);
        pulse("R8 gated", 64'h1 << 5, 64'h0);
        bus_write(8'h00, 32'h1);
        pulse("R8 ungated", 64'h1 << 5, 64'h1 << 9);
    endtask

    task automatic t_disabled();
        bus_write(8'h10, 32'h1 << 3);
        pulse("R9 disabled", 64'h1 << 5, 64'h0);
    endtask

    task automatic t_merge();
        quiesce();
        set_cfg(1, 8'd5, 8'd12);
        set_cfg(2, 8'd6, 8'd12);
        bus_write(8'h08, 32'h6);
        pulse("R10 merge", (64'h1 << 5) | (64'h1 << 6), 64'h1 << 12);
        set_cfg(2, 8'd5, 8'd13);
        pulse("R10 fan-out", 64'h1 << 5, (64'h1 << 12) | (64'h1 << 13));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_enable_words();
        t_config();
        t_route();
        t_null_ids();
        t_gate();
        t_disabled();
        t_merge();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule